// File: doc/BRIEF.md
# Four-Bit Maximal-Length Pseudo-Random Sequence Generator

The block is a four-bit linear feedback shift register that walks through all fifteen non-zero four-bit codes before it repeats. Its state bits are named QA, QB, QC and QD. On every enabled clock edge QA moves into QB, QB into QC and QC into QD. The new QA is the exclusive OR of the old QC and QD. The state is presented as a four-bit word, and QD is also given out alone as a serial bit stream.

The all-zero code is a lock-up: an LFSR in that code would never leave it. The block spots that code and replaces it with the seed 1000 on the next edge. A synchronous reset also loads that seed. A synchronous load port lets a user place any code, the zero code included, into the register, and this is what makes the escape path reachable.

Each edge makes one of five transitions, named for what happens to the state. STEP_SEED is reset to 1000. STEP_LOAD takes the load value. STEP_ESCAPE leaves 0000 for 1000. STEP_SHIFT is one LFSR step. STEP_HOLD keeps the state. When several conditions are true on the same edge, the one listed first wins.

Top module: `lfsr_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes 1000 (QA=1) on that edge, whatever the other inputs are.
- R2: With `rst` and `load_en` low, `enable` low and a non-zero state, the state does not change across an edge.
- R3: With `rst` and `load_en` low, `enable` high and a non-zero state, one edge moves the state from {QA,QB,QC,QD} to {QC xor QD, QA, QB, QC}.
- R4: Starting from 1000 with `enable` held high, the states come in this order: 1000, 0100, 0010, 1001, 1100, 0110, 1011, 0101, 1010, 1101, 1110, 1111, 0111, 0011, 0001. The state then returns to 1000.
- R5: Over those fifteen enabled steps every non-zero code appears exactly once and 0000 never appears.
- R6: With `rst` low and `load_en` high, the state takes `load_val` on the next edge. This has priority over `enable` and over the zero escape.
- R7: With `rst` and `load_en` low and a state of 0000, the next edge sets the state to 1000, whether `enable` is high or low.
- R8: `serial_out` always equals QD, which is `state[0]`.
- R9: When `rst` and `load_en` are both high on the same edge, reset wins and the state becomes 1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; loads seed 1000 |
| enable | input | 1 | Advance one LFSR step per edge when high |
| load_en | input | 1 | Synchronous load of `load_val` |
| load_val | input | 4 | Code to load, bit 3 = QA, bit 0 = QD |
| state | output | 4 | Current state, bit 3 = QA, bit 0 = QD |
| serial_out | output | 1 | Serial bit stream, equal to QD |

## Verification
The bench follows the whole fifteen-state loop from the seed and checks the state after every step. Wrong taps or a reversed shift direction would give a different order or a shorter cycle. It loads 0000 and then holds `enable` low. A design that escaped only while enabled would stay locked at zero, and one with no escape at all would never leave zero. Reset and load are raised on the same edge to catch an inverted priority. Random runs mix load, hold, step and reset and check each edge against a bench model.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

    localparam int LFSR_W = 4;

    typedef logic [LFSR_W-1:0] lfsr_word_t;

    typedef enum logic [2:0] {
        STEP_HOLD   = 3'd0,
        STEP_SHIFT  = 3'd1,
        STEP_ESCAPE = 3'd2,
        STEP_LOAD   = 3'd3,
        STEP_SEED   = 3'd4
    } step_kind_e;

    localparam lfsr_word_t LFSR_SEED = 4'b1000;

endpackage

// File: rtl/lfsr_step.sv
module lfsr_step
    import lfsr_pkg::*;
#(
    parameter int         TAP_HI = 1,
    parameter int         TAP_LO = 0,
    parameter lfsr_word_t SEED   = LFSR_SEED
) (
    input  lfsr_word_t cur,
    input  logic       rst,
    input  logic       enable,
    input  logic       load_en,
    input  lfsr_word_t load_val,
    output step_kind_e kind,
    output lfsr_word_t nxt
);

    localparam int MSB = LFSR_W - 1;

    logic       is_zero;
    logic       fb_bit;
    lfsr_word_t shifted;

    assign is_zero = (cur == '0);
    assign fb_bit  = cur[TAP_HI] ^ cur[TAP_LO];
    assign shifted = {fb_bit, cur[MSB:1]};

    always_comb begin
        if (rst)
            kind = STEP_SEED;
        else if (load_en)
            kind = STEP_LOAD;
        else if (is_zero)
            kind = STEP_ESCAPE;
        else if (enable)
            kind = STEP_SHIFT;
        else
            kind = STEP_HOLD;
    end

    always_comb begin
        unique case (kind)
            STEP_SEED:   nxt = SEED;
            STEP_LOAD:   nxt = load_val;
            STEP_ESCAPE: nxt = SEED;
            STEP_SHIFT:  nxt = shifted;
            STEP_HOLD:   nxt = cur;
            default:     nxt = SEED;
        endcase
    end

endmodule

// File: rtl/lfsr_state_reg.sv
module lfsr_state_reg
    import lfsr_pkg::*;
(
    input  logic       clk,
    input  lfsr_word_t nxt,
    output lfsr_word_t cur
);

    always_ff @(posedge clk) begin
        cur <= nxt;
    end

endmodule

// File: rtl/lfsr_gen.sv
module lfsr_gen
    import lfsr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic                load_en,
    input  logic [LFSR_W-1:0]   load_val,
    output logic [LFSR_W-1:0]   state,
    output logic                serial_out
);

    lfsr_word_t cur_q;
    lfsr_word_t nxt_d;
    step_kind_e kind_d;

    lfsr_step #(
        .TAP_HI (1),
        .TAP_LO (0),
        .SEED   (LFSR_SEED)
    ) u_step (
        .cur      (cur_q),
        .rst      (rst),
        .enable   (enable),
        .load_en  (load_en),
        .load_val (load_val),
        .kind     (kind_d),
        .nxt      (nxt_d)
    );

    lfsr_state_reg u_reg (
        .clk (clk),
        .nxt (nxt_d),
        .cur (cur_q)
    );

    always_comb begin
        state      = cur_q;
        serial_out = cur_q[0];
    end

endmodule

// File: rtl/lfsr_gen_chk.sv
module lfsr_gen_chk
    import lfsr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              enable,
    input logic              load_en,
    input logic [LFSR_W-1:0] load_val,
    input logic [LFSR_W-1:0] state,
    input logic              serial_out
);

    p_seed_on_reset_r1: assert property (@(posedge clk)
        rst |=> (state == LFSR_SEED));

    p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !enable && state != '0) |=> $stable(state));

    p_shift_step_r3: assert property (@(posedge clk) disable iff (rst)
        (!load_en && enable && state != '0) |=>
            (state == {$past(state[1] ^ state[0]), $past(state[3:1])}));

    p_load_value_r6: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (state == $past(load_val)));

    p_zero_escape_r7: assert property (@(posedge clk) disable iff (rst)
        (!load_en && state == '0) |=> (state == LFSR_SEED));

    p_reset_over_load_r9: assert property (@(posedge clk)
        (rst && load_en) |=> (state == LFSR_SEED));

    always_comb begin
        if (!$isunknown(state))
            a_serial_is_qd_r8: assert (serial_out == state[0]);
    end

endmodule

bind lfsr_gen lfsr_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .load_en    (load_en),
    .load_val   (load_val),
    .state      (state),
    .serial_out (serial_out)
);

// File: tb/sim_lfsr_gen.sv
`timescale 1ns/1ps
module sim_lfsr_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       load_en = 1'b0;
    logic [3:0] load_val = 4'b0;
    logic [3:0] state;
    logic       serial_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [3:0] exp_q = 4'b1000;

    always #2 clk = ~clk;

    lfsr_gen u0 (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .load_en    (load_en),
        .load_val   (load_val),
        .state      (state),
        .serial_out (serial_out)
    );

    function automatic logic [3:0] model_next(input logic [3:0] c, input logic r,
                                              input logic ld, input logic [3:0] lv,
                                              input logic en);
        if (r)              return 4'b1000;
        if (ld)             return lv;
        if (c == 4'b0000)   return 4'b1000;
        if (en)             return {c[1] ^ c[0], c[3], c[2], c[1]};
        return c;
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic cyc(input logic r, input logic ld, input logic [3:0] lv,
                       input logic en, input string req);
        @(negedge clk);
        rst = r; load_en = ld; load_val = lv; enable = en;
        exp_q = model_next(exp_q, r, ld, lv, en);
        @(posedge clk);
        #1;
        check(req, state, exp_q);
        check("R8", {3'b0, serial_out}, {3'b0, state[0]});
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [3:0] order [15];
        logic [15:0] seen;
        order = '{4'b1000, 4'b0100, 4'b0010, 4'b1001, 4'b1100, 4'b0110, 4'b1011,
                  4'b0101, 4'b1010, 4'b1101, 4'b1110, 4'b1111, 4'b0111, 4'b0011,
                  4'b0001};
        void'($urandom(32'h5EED_1234));

        // R1: reset loads seed
        cyc(1'b1, 1'b0, 4'h0, 1'b1, "R1");
        cyc(1'b1, 1'b0, 4'h0, 1'b0, "R1");

        // R4 and R5: full loop
        seen = 16'h0001;
        for (int i = 1; i <= 15; i++) begin
            cyc(1'b0, 1'b0, 4'h0, 1'b1, "R3");
            check("R4", state, order[i % 15]);
            if (i < 15) seen[state] = 1'b1;
        end
        check("R5", {3'b0, seen[0]}, 4'b0001);
        checks++;
        if ($countones(seen) != 15) begin
            fails++;
            $display("FAIL R5: actual %0d distinct expected 15", $countones(seen) - 1);
        end

        // R2: hold
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 4'h0, 1'b0, "R2");

        // R6: load beats enable
        cyc(1'b0, 1'b1, 4'b0110, 1'b1, "R6");
        cyc(1'b0, 1'b0, 4'h0, 1'b1, "R3");

        // R7: zero escape with enable low, and with enable high
        cyc(1'b0, 1'b1, 4'b0000, 1'b0, "R6");
        cyc(1'b0, 1'b0, 4'h0, 1'b0, "R7");
        check("R7", state, 4'b1000);
        cyc(1'b0, 1'b1, 4'b0000, 1'b1, "R6");
        cyc(1'b0, 1'b0, 4'h0, 1'b1, "R7");
        check("R7", state, 4'b1000);

        // R9: reset over load
        cyc(1'b0, 1'b1, 4'b0101, 1'b0, "R6");
        cyc(1'b1, 1'b1, 4'b0011, 1'b1, "R9");
        check("R9", state, 4'b1000);

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic r, ld, en;
            logic [3:0] lv;
            r  = (($urandom % 40) == 0);
            ld = (($urandom % 10) == 0);
            en = (($urandom % 4) != 0);
            lv = (($urandom % 3) == 0) ? 4'b0000 : 4'($urandom);
            cyc(r, ld, lv, en, "R3");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule